// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. On every phase-detector cycle it receives two single-cycle strobes, one for the reference edge and one for the feedback edge. It counts cycles of a fast sampling clock from whichever strobe comes first to the strobe of the other kind. The count is the phase error of that cycle. Each error is placed in one of three bands using two thresholds, both given in sampling-clock cycles: a small lock threshold (the equivalent of 15 ns) and a larger unlock threshold (the equivalent of 25 ns).

The lock flag is active high and has asymmetric hysteresis. While unlocked, the block counts consecutive cycles whose error is below the lock threshold. It raises the flag after three such cycles, or after five when the precision input is set. Once locked, the flag drops only on a cycle whose error exceeds the unlock threshold. Errors in the band between the two thresholds neither lengthen a run toward lock nor break an existing lock. The measured error is also presented with a one-cycle valid strobe, so that loop firmware or a monitor can observe it.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `locked` and `err_valid` are 0.
- R2: The error equals the number of rising clock edges from the edge that samples the leading strobe to the edge that samples the trailing strobe of the other kind, whichever kind leads. Both strobes in the same cycle give an error of 0. `err_valid` is high for exactly the one cycle after the trailing strobe is sampled, and `err_cycles` holds the error during that cycle.
- R3: With `precise` = 0, `locked` rises one cycle after the `err_valid` of the third consecutive error below `lock_thr`.
- R4: With `precise` = 1, five consecutive errors below `lock_thr` are needed. After four, `locked` is still 0.
- R5: While unlocked, an error greater than or equal to `lock_thr` resets the run of good cycles to zero.
- R6: While locked, an error greater than `unlock_thr` clears `locked` one cycle after its `err_valid`. A fresh full run of good cycles is then needed to lock again.
- R7: While locked, an error less than or equal to `unlock_thr`, including one in the band between the thresholds, leaves `locked` at 1.
- R8: The error count saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R9: A further strobe of the leading kind while a measurement is open is ignored. The error is still measured from the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_edge | input | 1 | One-cycle strobe marking a reference edge |
| fb_edge | input | 1 | One-cycle strobe marking a feedback edge |
| precise | input | 1 | 0: three good cycles to lock; 1: five |
| lock_thr | input | CNT_W | Errors strictly below this count as good |
| unlock_thr | input | CNT_W | Errors strictly above this break lock |
| locked | output | 1 | Active-high lock indication |
| err_valid | output | 1 | One-cycle strobe marking a new error measurement |
| err_cycles | output | CNT_W | Last measured phase error in clock cycles |

## Verification
The assertions rely on three properties of the inputs. Each strobe is high for exactly one clock cycle. `unlock_thr` is at least `lock_thr`. The thresholds and `precise` stay constant while the block is out of reset. The bench keeps to these rules. It drives each strobe for a single cycle on the falling edge and holds both thresholds fixed for the whole run. It changes `precise` only while reset is applied. Within those limits, the bench sweeps the error through every value around both thresholds, with either strobe leading, in both precision modes.

// File: rtl/pll_lock_detect_pkg.sv
package pll_lock_detect_pkg;

  typedef enum logic [1:0] {
    ERR_GOOD = 2'd0,
    ERR_MID  = 2'd1,
    ERR_BAD  = 2'd2
  } err_band_e;

  localparam int unsigned RUN_COARSE = 3;
  localparam int unsigned RUN_FINE   = 5;
  localparam int unsigned RUN_W      = $clog2(RUN_FINE + 1);

endpackage

// File: rtl/ld_phase_meter.sv
module ld_phase_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             fb_edge,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q,  open_n;
  logic             lead_ref_q, lead_ref_n;
  logic [CNT_W-1:0] cnt_q,   cnt_n;
  logic             cnt_en;
  logic             valid_q, valid_n;
  logic [CNT_W-1:0] err_q,   err_n;
  logic             err_en;
  logic             close_w;

  assign close_w = open_q && (lead_ref_q ? fb_edge : ref_edge);

  always_comb begin
    open_n     = open_q;
    lead_ref_n = lead_ref_q;
    cnt_n      = cnt_q;
    cnt_en     = 1'b0;
    valid_n    = 1'b0;
    err_n      = err_q;
    err_en     = 1'b0;
    if (!open_q) begin
      if (ref_edge && fb_edge) begin
        valid_n = 1'b1;
        err_n   = '0;
        err_en  = 1'b1;
      end else if (ref_edge || fb_edge) begin
        open_n     = 1'b1;
        lead_ref_n = ref_edge;
        cnt_n      = {{(CNT_W-1){1'b0}}, 1'b1};
        cnt_en     = 1'b1;
      end
    end else if (close_w) begin
      open_n  = 1'b0;
      valid_n = 1'b1;
      err_n   = cnt_q;
      err_en  = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_n  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      lead_ref_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      open_q     <= open_n;
      lead_ref_q <= lead_ref_n;
      valid_q    <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_n;
    end
  end

  assign meas_valid = valid_q;
  assign meas_err   = err_q;

  // R2: a trailing strobe of the other kind always yields a measurement next cycle
  p_close_gives_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && (lead_ref_q ? fb_edge : ref_edge)) |=> (meas_valid && !open_q));

  // R8: the running count never wraps back from its maximum
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R9: a repeated leading strobe keeps the window open
  p_lead_repeat_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && lead_ref_q && ref_edge && !fb_edge) |=> (open_q && lead_ref_q && !meas_valid));

endmodule

// File: rtl/ld_err_classify.sv
module ld_err_classify
  import pll_lock_detect_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] err,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output err_band_e        band
);

  always_comb begin
    if (err < lock_thr) begin
      band = ERR_GOOD;
    end else if (err > unlock_thr) begin
      band = ERR_BAD;
    end else begin
      band = ERR_MID;
    end
  end

endmodule

// File: rtl/ld_run_qualifier.sv
module ld_run_qualifier
  import pll_lock_detect_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      precise,
  input  logic      meas_valid,
  input  err_band_e band,
  output logic      locked
);

  logic [RUN_W-1:0] run_q, run_n;
  logic             run_en;
  logic             lock_q, lock_n;
  logic [RUN_W-1:0] target;

  assign target = precise ? RUN_W'(RUN_FINE) : RUN_W'(RUN_COARSE);

  always_comb begin
    run_n  = run_q;
    run_en = 1'b0;
    lock_n = lock_q;
    if (meas_valid) begin
      if (!lock_q) begin
        run_en = 1'b1;
        if (band == ERR_GOOD) begin
          if (run_q + 1'b1 == target) begin
            lock_n = 1'b1;
            run_n  = '0;
          end else begin
            run_n = run_q + 1'b1;
          end
        end else begin
          run_n = '0;
        end
      end else if (band == ERR_BAD) begin
        lock_n = 1'b0;
        run_n  = '0;
        run_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_n;
    end
  end

  assign locked = lock_q;

  // R3: the run never reaches the target while still counting
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q < target));

  // R4: lock rises only right after a good measurement
  p_rise_after_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(meas_valid && band == ERR_GOOD));

  // R5: a non-good error while unlocked empties the run
  p_run_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && meas_valid && band != ERR_GOOD) |=> (run_q == '0 && !lock_q));

  // R6: a large error while locked drops the flag and empties the run
  p_drop_on_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && meas_valid && band == ERR_BAD) |=> (!lock_q && run_q == '0));

  // R7: anything short of a large error keeps lock
  p_hold_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(meas_valid && band == ERR_BAD)) |=> lock_q);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_detect_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             fb_edge,
  input  logic             precise,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             locked,
  output logic             err_valid,
  output logic [CNT_W-1:0] err_cycles
);

  logic      rst_meta_q, rst_sync_q;
  logic      meas_valid;
  logic [CNT_W-1:0] meas_err;
  err_band_e band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ld_phase_meter #(.CNT_W(CNT_W)) meter_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .ref_edge   (ref_edge),
    .fb_edge    (fb_edge),
    .meas_valid (meas_valid),
    .meas_err   (meas_err)
  );

  ld_err_classify #(.CNT_W(CNT_W)) classify_i (
    .err        (meas_err),
    .lock_thr   (lock_thr),
    .unlock_thr (unlock_thr),
    .band       (band)
  );

  ld_run_qualifier qualify_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .precise    (precise),
    .meas_valid (meas_valid),
    .band       (band),
    .locked     (locked)
  );

  assign err_valid  = meas_valid;
  assign err_cycles = meas_err;

  // R2: a measurement strobe lasts one cycle
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    err_valid |=> !err_valid);

  // R7: lock changes only after a measurement
  p_lock_moves_on_meas_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !err_valid |=> $stable(locked));

endmodule

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;

  localparam int unsigned CNT_W = 8;
  localparam int LT = 4;
  localparam int UT = 7;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_edge = 1'b0;
  logic             fb_edge = 1'b0;
  logic             precise = 1'b0;
  logic [CNT_W-1:0] lock_thr = CNT_W'(LT);
  logic [CNT_W-1:0] unlock_thr = CNT_W'(UT);
  logic             locked;
  logic             err_valid;
  logic [CNT_W-1:0] err_cycles;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  int m_run = 0;
  bit m_lock = 0;
  string m_tag = "R3";

  always #10 clk = ~clk;

  pll_lock_detect #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_edge   (ref_edge),
    .fb_edge    (fb_edge),
    .precise    (precise),
    .lock_thr   (lock_thr),
    .unlock_thr (unlock_thr),
    .locked     (locked),
    .err_valid  (err_valid),
    .err_cycles (err_cycles)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst_n = 1'b0;
    precise = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_run = 0;
    m_lock = 0;
    check("R1 locked after reset", int'(locked), 0);
    check("R1 err_valid after reset", int'(err_valid), 0);
  endtask

  function automatic void model(int d);
    int tgt = precise ? 5 : 3;
    m_tag = precise ? "R4" : "R3";
    if (!m_lock) begin
      if (d < LT) begin
        m_run++;
        if (m_run == tgt) begin
          m_lock = 1;
          m_run = 0;
        end
      end else begin
        m_run = 0;
        m_tag = "R5";
      end
    end else if (d > UT) begin
      m_lock = 0;
      m_run = 0;
      m_tag = "R6";
    end else begin
      m_tag = "R7";
    end
  endfunction

  task automatic run_pair(bit ref_lead, int d);
    int exp_err;
    @(negedge clk);
    if (d == 0) begin
      ref_edge = 1'b1;
      fb_edge = 1'b1;
    end else if (ref_lead) ref_edge = 1'b1;
    else fb_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
    fb_edge = 1'b0;
    if (d > 0) begin
      repeat (d - 1) @(negedge clk);
      if (ref_lead) fb_edge = 1'b1;
      else ref_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0;
      fb_edge = 1'b0;
    end
    exp_err = (d > CMAX) ? CMAX : d;
    check("R2 err_valid", int'(err_valid), 1);
    check((d > CMAX) ? "R8 saturated error" : "R2 error", int'(err_cycles), exp_err);
    model(exp_err);
    @(negedge clk);
    check("R2 err_valid one cycle", int'(err_valid), 0);
    check(m_tag, int'(locked), int'(m_lock));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      do_reset(p[0]);
      // directed: one short of the required run, then the final good cycle
      for (int i = 0; i < (p ? 4 : 2); i++) run_pair(i[0], 1);
      check(p ? "R4 not yet locked" : "R3 not yet locked", int'(locked), 0);
      run_pair(1'b1, 3);
      check(p ? "R4 locked after five" : "R3 locked after three", int'(locked), 1);
      // mid-band and threshold-edge errors hold lock
      run_pair(1'b0, LT);
      run_pair(1'b1, UT);
      check("R7 lock held in mid band", int'(locked), 1);
      // a large error drops lock, relock needs a full fresh run
      run_pair(1'b0, UT + 1);
      check("R6 unlocked", int'(locked), 0);
      // sweep: each error value, both leads, embedded in good runs
      for (int rep = 0; rep < 3; rep++) begin
        for (int d = 0; d <= UT + 3; d++) begin
          for (int g = 0; g < rep + 2; g++) run_pair(g[0], g % LT);
          run_pair(d[0] ^ rep[0], d);
        end
      end
    end

    // R8: long separation saturates
    run_pair(1'b1, CMAX + 40);

    // R9: a second leading strobe does not restart the window
    @(negedge clk); ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    @(negedge clk); ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    @(negedge clk); @(negedge clk); fb_edge = 1'b1;
    @(negedge clk); fb_edge = 1'b0;
    check("R9 err_valid", int'(err_valid), 1);
    check("R9 error from first strobe", int'(err_cycles), 5);
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule